// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of recently used page-table entries and maps a virtual address to a physical address. A lookup compares the virtual page number against every stored tag at once. On a hit it returns, in the same cycle, the physical address and the access flags of that entry. On a miss the lookup reports that a page-table walk is needed. The walker then hands its result to the refill port. A refill that carries a present page is stored. A refill that carries an absent page raises a fault and changes nothing.

Entries are replaced least-recently-used first, and free slots are filled before any valid entry is evicted. Each entry carries an age rank, and both lookup hits and refills count as a use. The operating system pulses the flush input whenever a different process starts running. This clears every entry, so no translation from the previous process survives.

Top module: `tlb_fa`

## Requirements
- R1: When `lk_valid` is high and a valid entry holds the requested page number (`lk_vaddr[31:12]`), `lk_hit` is 1 in the same cycle and `lk_paddr` equals {stored frame, `lk_vaddr[11:0]`}.
- R2: On a hit, `lk_ro`, `lk_user` and `lk_dirty` show the flags stored with the matching entry. Without a hit they are 0.
- R3: When `lk_valid` is high and no valid entry matches, `lk_miss` is 1 and `lk_hit` is 0. When `lk_valid` is low, both are 0.
- R4: A refill (`rf_valid`=1, `rf_present`=1, no flush) stores its page, frame and flags. A lookup of that page hits from the next cycle on.
- R5: A refill with `rf_present`=0 drives `fault` to 1 in the same cycle. It stores nothing and evicts nothing.
- R6: After reset, and from the cycle after a `flush` pulse, every lookup misses.
- R7: A `flush` in the same cycle as a refill wins. The refilled page is not stored.
- R8: A refill whose page number is already stored overwrites that entry in place. No other entry is evicted, and no two valid entries share a tag.
- R9: While a free slot exists, a refill fills a free slot. Sixteen distinct refills after a flush all remain resident.
- R10: When the buffer is full, a refill evicts the entry used least recently. Both lookup hits and refills count as uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Walk required |
| lk_paddr | output | 32 | Physical address on hit |
| lk_ro | output | 1 | Entry is read-only |
| lk_user | output | 1 | Entry is user-accessible |
| lk_dirty | output | 1 | Entry is modified |
| rf_valid | input | 1 | Walk result present |
| rf_present | input | 1 | Walked page is resident |
| rf_vpn | input | 20 | Page number of refill |
| rf_ppn | input | 20 | Frame number of refill |
| rf_ro | input | 1 | Read-only flag of refill |
| rf_user | input | 1 | User flag of refill |
| rf_dirty | input | 1 | Dirty flag of refill |
| fault | output | 1 | Refilled page not resident |

## Verification
A corrupted age rank does not show at once. It appears only at the next refill into a full buffer, when the wrong page is evicted. A lookup of the page that should have survived then misses. The bench therefore sets up a known use order and probes both the evicted page and the protected page after every refill. A stale valid bit or a duplicated tag shows on the very next lookup, as a hit after a flush or as a wrong frame.

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   lk_valid,
  input  logic [VPN_W+OFF_W-1:0] lk_vaddr,
  output logic                   lk_hit,
  output logic                   lk_miss,
  output logic [PPN_W+OFF_W-1:0] lk_paddr,
  output logic                   lk_ro,
  output logic                   lk_user,
  output logic                   lk_dirty,
  input  logic                   rf_valid,
  input  logic                   rf_present,
  input  logic [VPN_W-1:0]       rf_vpn,
  input  logic [PPN_W-1:0]       rf_ppn,
  input  logic                   rf_ro,
  input  logic                   rf_user,
  input  logic                   rf_dirty,
  output logic                   fault
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] OLDEST = IW'(ENTRIES - 1);

  logic             valid_q [ENTRIES];
  logic [VPN_W-1:0] tag_q   [ENTRIES];
  logic [PPN_W-1:0] frame_q [ENTRIES];
  logic             ro_q    [ENTRIES];
  logic             user_q  [ENTRIES];
  logic             dirty_q [ENTRIES];
  logic [IW-1:0]    age_q   [ENTRIES];

  logic [ENTRIES-1:0] hit_vec, rf_vec;
  logic [IW-1:0] hit_idx, rf_idx, free_idx, lru_idx, wr_idx, touch_idx, touch_age;
  logic have_free, wr_en, touch_en;

  wire [VPN_W-1:0] lk_vpn = lk_vaddr[VPN_W+OFF_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_vpn);
    assign rf_vec[g]  = valid_q[g] && (tag_q[g] == rf_vpn);
  end

  always_comb begin
    hit_idx   = '0;
    rf_idx    = '0;
    free_idx  = '0;
    lru_idx   = '0;
    have_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IW'(i);
      if (rf_vec[i])  rf_idx  = IW'(i);
      if (!valid_q[i]) begin
        free_idx  = IW'(i);
        have_free = 1'b1;
      end
      if (age_q[i] == OLDEST) lru_idx = IW'(i);
    end
  end

  assign lk_hit   = lk_valid && (|hit_vec);
  assign lk_miss  = lk_valid && !(|hit_vec);
  assign lk_paddr = lk_hit ? {frame_q[hit_idx], lk_vaddr[OFF_W-1:0]} : '0;
  assign lk_ro    = lk_hit && ro_q[hit_idx];
  assign lk_user  = lk_hit && user_q[hit_idx];
  assign lk_dirty = lk_hit && dirty_q[hit_idx];

  assign fault     = rf_valid && !rf_present;
  assign wr_en     = rf_valid && rf_present && !flush;
  assign wr_idx    = (|rf_vec) ? rf_idx : (have_free ? free_idx : lru_idx);
  assign touch_en  = !flush && (wr_en || lk_hit);
  assign touch_idx = wr_en ? wr_idx : hit_idx;
  assign touch_age = age_q[touch_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
        frame_q[i] <= '0;
        ro_q[i]    <= 1'b0;
        user_q[i]  <= 1'b0;
        dirty_q[i] <= 1'b0;
        age_q[i]   <= IW'(i);
      end
    end else begin
      if (flush) begin
        for (int i = 0; i < ENTRIES; i++) valid_q[i] <= 1'b0;
      end else if (wr_en) begin
        valid_q[wr_idx] <= 1'b1;
        tag_q[wr_idx]   <= rf_vpn;
        frame_q[wr_idx] <= rf_ppn;
        ro_q[wr_idx]    <= rf_ro;
        user_q[wr_idx]  <= rf_user;
        dirty_q[wr_idx] <= rf_dirty;
      end
      if (touch_en) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IW'(i) == touch_idx)      age_q[i] <= '0;
          else if (age_q[i] < touch_age) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end
endmodule

module tlb_fa_chk #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flush,
  input logic                   lk_valid,
  input logic [VPN_W+OFF_W-1:0] lk_vaddr,
  input logic                   lk_hit,
  input logic [PPN_W+OFF_W-1:0] lk_paddr,
  input logic                   rf_valid,
  input logic                   rf_present,
  input logic [VPN_W-1:0]       rf_vpn,
  input logic [PPN_W-1:0]       rf_ppn,
  input logic [ENTRIES-1:0]     hit_vec,
  input logic [ENTRIES-1:0]     rf_vec
);
  // R6
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  // R8
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec) && $onehot0(rf_vec));

  // R4
  refill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rf_valid && rf_present && !flush) && lk_valid &&
     lk_vaddr[VPN_W+OFF_W-1:OFF_W] == $past(rf_vpn))
    |-> (lk_hit && lk_paddr[PPN_W+OFF_W-1:OFF_W] == $past(rf_ppn)));

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

  // R5
  absent_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rf_valid && !rf_present && !(|rf_vec)) &&
     lk_valid && lk_vaddr[VPN_W+OFF_W-1:OFF_W] == $past(rf_vpn) &&
     $past(!(lk_valid && lk_vaddr[VPN_W+OFF_W-1:OFF_W] == rf_vpn && lk_hit)))
    |-> !lk_hit);
endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_hit(lk_hit), .lk_paddr(lk_paddr), .rf_valid(rf_valid), .rf_present(rf_present),
  .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .hit_vec(hit_vec), .rf_vec(rf_vec));

// File: tb/test_tlb_fa.sv
module test_tlb_fa;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic lk_hit, lk_miss, lk_ro, lk_user, lk_dirty, fault;
  logic [31:0] lk_paddr;
  logic rf_valid = 1'b0, rf_present = 1'b0, rf_ro = 1'b0, rf_user = 1'b0, rf_dirty = 1'b0;
  logic [19:0] rf_vpn = '0, rf_ppn = '0;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  tlb_fa i_tlb_fa (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr), .lk_ro(lk_ro),
    .lk_user(lk_user), .lk_dirty(lk_dirty), .rf_valid(rf_valid), .rf_present(rf_present),
    .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_ro(rf_ro), .rf_user(rf_user),
    .rf_dirty(rf_dirty), .fault(fault));

  function automatic logic [19:0] frame_of(int v);
    return 20'(v * 3 + 256);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(input int vpn, input int off, input bit exp_hit, input logic [19:0] exp_ppn, input string req);
    logic [2:0] fl;
    @(negedge clk);
    rf_valid = 1'b0;
    flush = 1'b0;
    lk_valid = 1'b1;
    lk_vaddr = {20'(vpn), 12'(off)};
    #2;
    chk(lk_hit == exp_hit && lk_miss == !exp_hit, req, {lk_hit, lk_miss}, {exp_hit, !exp_hit});
    fl = exp_hit ? 3'(vpn) : 3'b0;
    chk(lk_paddr == (exp_hit ? {exp_ppn, 12'(off)} : 32'h0), req, lk_paddr, {exp_ppn, 12'(off)});
    chk({lk_ro, lk_user, lk_dirty} == {fl[0], fl[1], fl[2]}, "R2", {lk_ro, lk_user, lk_dirty}, {fl[0], fl[1], fl[2]});
  endtask

  task automatic refill(input int vpn, input logic [19:0] ppn, input bit present, input bit fl);
    @(negedge clk);
    lk_valid = 1'b0;
    rf_valid = 1'b1;
    rf_present = present;
    rf_vpn = 20'(vpn);
    rf_ppn = ppn;
    rf_ro = vpn[0];
    rf_user = vpn[1];
    rf_dirty = vpn[2];
    flush = fl;
    #2;
    chk(fault == !present, "R5", fault, !present);
    @(negedge clk);
    rf_valid = 1'b0;
    flush = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    lk_valid = 1'b0;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6: reset state empty
    look(0, 0, 1'b0, 20'h0, "R6");
    look(5, 12, 1'b0, 20'h0, "R6");
    // R3: idle lookup reports nothing
    @(negedge clk);
    lk_valid = 1'b0;
    #2;
    chk(!lk_hit && !lk_miss, "R3", {lk_hit, lk_miss}, 2'b00);

    // R9: fill all sixteen free slots
    for (int v = 0; v < 16; v++) refill(v, frame_of(v), 1'b1, 1'b0);
    // R1 R3 R4: sweep pages and offsets
    for (int o = 0; o < 3; o++) begin
      for (int v = 0; v < 32; v++) begin
        int off = (o == 0) ? 0 : ((o == 1) ? 12'hABC : 12'hFFF);
        look(v, off, v < 16, frame_of(v), v < 16 ? "R1" : "R3");
      end
    end

    // R10: use order now 0 oldest; touch page 0 so page 1 becomes oldest
    look(0, 7, 1'b1, frame_of(0), "R10");
    refill(100, frame_of(100), 1'b1, 1'b0);
    look(1, 0, 1'b0, 20'h0, "R10");
    refill(101, frame_of(101), 1'b1, 1'b0);
    look(2, 0, 1'b0, 20'h0, "R10");
    look(100, 1, 1'b1, frame_of(100), "R10");
    look(101, 2, 1'b1, frame_of(101), "R10");
    look(0, 3, 1'b1, frame_of(0), "R10");

    // R8: overwrite page 0; page 3 (oldest) must survive
    refill(0, 20'h55555, 1'b1, 1'b0);
    look(0, 9, 1'b1, 20'h55555, "R8");
    look(3, 9, 1'b1, frame_of(3), "R8");

    // R5: absent page faults, no store, oldest page 4 survives
    refill(200, frame_of(200), 1'b0, 1'b0);
    look(200, 0, 1'b0, 20'h0, "R5");
    look(4, 0, 1'b1, frame_of(4), "R5");

    // R6: flush empties everything
    pulse_flush();
    for (int v = 0; v < 16; v++) look(v, v, 1'b0, 20'h0, "R6");
    look(100, 0, 1'b0, 20'h0, "R6");
    look(101, 0, 1'b0, 20'h0, "R6");

    // R4 then R7
    refill(7, frame_of(7), 1'b1, 1'b0);
    look(7, 5, 1'b1, frame_of(7), "R4");
    refill(9, frame_of(9), 1'b1, 1'b1);
    look(9, 0, 1'b0, 20'h0, "R7");
    look(7, 0, 1'b0, 20'h0, "R7");

    @(negedge clk);
    lk_valid = 1'b0;
    summary();
    $finish;
  end
endmodule